// File: doc/BRIEF.md
# Clock Output Gating Controller

This block sits between the internally synthesized clocks of a board clock generator and its output pins. For every output it decides whether the clock passes through, is held low, or whether the whole output bank is released to high impedance. A CPU stop pin, a shared pin that works as a PCI stop pin only under one strap setting, per-output enable bits, a two-bit operating-mode field and a test-mode bit are the controls.

All source clocks are presented as levels sampled by one fast sampling clock `clk`. Each gated output is owned by a small four-state machine with the states RUN, DRAIN, HALT and ARM. A stop or disable request in RUN moves to DRAIN while the source is high (RUN->DRAIN), or straight to HALT when the source is already low (RUN->HALT). DRAIN waits for the falling source edge (DRAIN->HALT) or returns to RUN if the request goes away (DRAIN->RUN). HALT holds the output low. When the request clears it goes to RUN if the source is low (HALT->RUN) and otherwise to ARM (HALT->ARM). ARM waits for a low source before running (ARM->RUN) and falls back to HALT if a request returns (ARM->HALT). Reset enters ARM. As a result an output never shows a shortened high phase. A second two-state machine, SAMPLE and LOCKED, captures the strap once after reset (SAMPLE->LOCKED) and then stays in LOCKED. In test mode the reference outputs carry the crystal level, and the USB outputs carry divided copies of the crystal. Spread mode is only reported on a status output.

Top module: `clk_gate_ctrl`

## Requirements
- R1: While `rst_n` is low every gated output is low. After reset an output first goes high only on a rising edge of its source that follows a low source level.
- R2: With `cpu_stop_n` low (seen through a `SYNC_STAGES`-deep synchronizer, default 2), `cpu_out` finishes its current high phase and then rests low. It never shows a high phase shorter than the source high phase.
- R3: After a stop or disable is released, an output resumes only at a rising source edge, so its first high phase is full length.
- R4: `cpu_free_out`, `ref1_out`, `apic_out`, `out48`, `out24` and `sdram_out` ignore `cpu_stop_n`. `cpu_free_out` and `pci_free_out` only ever rise together with their source.
- R5: `mode_strap` is captured in the first clock after reset is released. Later changes of `mode_strap` have no effect until the next reset.
- R6: With the captured strap at 0, `pcistop_pin` low stops all bits of `pci_out` (low, cycle-completing), `pci_free_out` keeps following `pci_src`, and `ref0_out` is held low.
- R7: With the captured strap at 1, `ref0_out` follows its source and `pci_out` follows `pci_src` whatever level `pcistop_pin` has.
- R8: An enable bit at 0 holds its output low after the current high phase completes. The output is not floated: `out_drive` stays 1.
- R9: `sdram_free_out` always equals `sdram_src`, regardless of enables, stop pins or strap.
- R10: `op_mode` encodings: 2'b00 normal (`out_drive`=1, `spread_on`=0); 2'b10 spread (`out_drive`=1, `spread_on`=1); 2'b11 high impedance (`out_drive`=0, `spread_on`=0); 2'b01 behaves as normal. The status outputs follow `op_mode` one clock later.
- R11: With `test_en`=1, `ref0_out`, `ref1_out` and `apic_out` carry `xtal_src`, `out48` toggles at half the crystal rate and `out24` at a quarter of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for all logic |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_src | input | 1 | Synthesized CPU clock level |
| pci_src | input | 1 | Synthesized PCI clock level |
| ref_src | input | 1 | Reference clock level |
| sdram_src | input | 1 | Buffered memory clock level |
| usb48_src | input | 1 | 48 MHz clock level |
| usb24_src | input | 1 | 24 MHz clock level |
| xtal_src | input | 1 | Crystal level used in test mode |
| cpu_stop_n | input | 1 | Active-low CPU stop request |
| pcistop_pin | input | 1 | Shared pin, active-low PCI stop when strap is 0 |
| mode_strap | input | 1 | Strap selecting the shared pin's function |
| op_mode | input | 2 | Operating mode field |
| test_en | input | 1 | Test mode select, active high |
| en_cpu | input | 1 | Enable for `cpu_out` |
| en_cpu_free | input | 1 | Enable for `cpu_free_out` |
| en_pci | input | N_PCI | Enables for `pci_out` |
| en_pci_free | input | 1 | Enable for `pci_free_out` |
| en_ref0 | input | 1 | Enable for `ref0_out` |
| en_ref1 | input | 1 | Enable for `ref1_out` |
| en_apic | input | 1 | Enable for `apic_out` |
| en_48 | input | 1 | Enable for `out48` |
| en_24 | input | 1 | Enable for `out24` |
| en_sdram | input | N_SDG | Enables, one per memory clock group |
| cpu_out | output | 1 | Stoppable CPU clock |
| cpu_free_out | output | 1 | Free-running CPU clock |
| pci_out | output | N_PCI | Stoppable PCI clocks |
| pci_free_out | output | 1 | Free-running PCI clock |
| ref0_out | output | 1 | Reference clock on the shared pin |
| ref1_out | output | 1 | Second reference clock |
| apic_out | output | 1 | Interrupt controller reference clock |
| out48 | output | 1 | 48 MHz output |
| out24 | output | 1 | 24 MHz output |
| sdram_out | output | N_SDG*SDR_PER_GRP | Gated memory clocks |
| sdram_free_out | output | 1 | Ungated memory clock |
| out_drive | output | 1 | Output buffer enable, 0 means high impedance |
| spread_on | output | 1 | Spread mode status |

## Verification
The bench drives stop and disable requests at arbitrary source phases and measures every completed high phase of the stoppable CPU and PCI outputs. A design that cut a high phase short would leave a runt pulse that the length count reports. A design that resumed mid-phase would do the same. It flips the strap after reset to catch a design that keeps sampling it, and it asserts the shared pin under both strap values, which would expose a design that stops PCI clocks when it should pass them or leaves the reference running when it should be held low. Test mode is checked by counting divided edges against crystal edges, which exposes a wrong divide ratio.

// File: rtl/clkg_pkg.sv
package clkg_pkg;

    typedef enum logic [1:0] {
        GS_RUN   = 2'd0,
        GS_DRAIN = 2'd1,
        GS_HALT  = 2'd2,
        GS_ARM   = 2'd3
    } gate_state_t;

    typedef enum logic {
        SP_SAMPLE = 1'b0,
        SP_LOCKED = 1'b1
    } strap_state_t;

    localparam logic [1:0] OPM_NORMAL = 2'b00;
    localparam logic [1:0] OPM_RSVD   = 2'b01;
    localparam logic [1:0] OPM_SPREAD = 2'b10;
    localparam logic [1:0] OPM_HIZ    = 2'b11;

endpackage

// File: rtl/clkg_sync.sv
module clkg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg <= {STAGES{RST_VAL}};
        end else begin
            shreg <= {shreg[STAGES-2:0], d};
        end
    end

    assign q = shreg[STAGES-1];
endmodule

// File: rtl/clkg_gate.sv
module clkg_gate
    import clkg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic src,
    input  logic stop,
    output logic gout
);
    gate_state_t state_q, state_d;
    logic        pass;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            GS_RUN:   if (stop) state_d = src ? GS_DRAIN : GS_HALT;
            GS_DRAIN: begin
                if (!stop)     state_d = GS_RUN;
                else if (!src) state_d = GS_HALT;
            end
            GS_HALT:  if (!stop) state_d = src ? GS_ARM : GS_RUN;
            GS_ARM: begin
                if (stop)      state_d = GS_HALT;
                else if (!src) state_d = GS_RUN;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= GS_ARM;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        pass = (state_q == GS_RUN) || (state_q == GS_DRAIN);
        gout = pass & src;
    end
endmodule

// File: rtl/clkg_xdiv.sv
module clkg_xdiv (
    input  logic clk,
    input  logic rst_n,
    input  logic xtal,
    output logic div2,
    output logic div4
);
    logic xtal_q;
    logic rise;

    assign rise = xtal & ~xtal_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xtal_q <= 1'b0;
            div2   <= 1'b0;
            div4   <= 1'b0;
        end else begin
            xtal_q <= xtal;
            if (rise) begin
                div2 <= ~div2;
                if (div2) div4 <= ~div4;
            end
        end
    end
endmodule

// File: rtl/clk_gate_ctrl.sv
module clk_gate_ctrl
    import clkg_pkg::*;
#(
    parameter int N_PCI       = 5,
    parameter int N_SDG       = 3,
    parameter int SDR_PER_GRP = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_src,
    input  logic                         pci_src,
    input  logic                         ref_src,
    input  logic                         sdram_src,
    input  logic                         usb48_src,
    input  logic                         usb24_src,
    input  logic                         xtal_src,
    input  logic                         cpu_stop_n,
    input  logic                         pcistop_pin,
    input  logic                         mode_strap,
    input  logic [1:0]                   op_mode,
    input  logic                         test_en,
    input  logic                         en_cpu,
    input  logic                         en_cpu_free,
    input  logic [N_PCI-1:0]             en_pci,
    input  logic                         en_pci_free,
    input  logic                         en_ref0,
    input  logic                         en_ref1,
    input  logic                         en_apic,
    input  logic                         en_48,
    input  logic                         en_24,
    input  logic [N_SDG-1:0]             en_sdram,
    output logic                         cpu_out,
    output logic                         cpu_free_out,
    output logic [N_PCI-1:0]             pci_out,
    output logic                         pci_free_out,
    output logic                         ref0_out,
    output logic                         ref1_out,
    output logic                         apic_out,
    output logic                         out48,
    output logic                         out24,
    output logic [N_SDG*SDR_PER_GRP-1:0] sdram_out,
    output logic                         sdram_free_out,
    output logic                         out_drive,
    output logic                         spread_on
);
    localparam int IDX_CPU  = 0;
    localparam int IDX_CPUF = 1;
    localparam int IDX_PCIF = 2;
    localparam int IDX_REF0 = 3;
    localparam int IDX_REF1 = 4;
    localparam int IDX_APIC = 5;
    localparam int IDX_U48  = 6;
    localparam int IDX_U24  = 7;
    localparam int IDX_PCI  = 8;
    localparam int IDX_SDG  = IDX_PCI + N_PCI;
    localparam int NG       = IDX_SDG + N_SDG;

    // strap capture machine
    strap_state_t strap_state_q, strap_state_d;
    logic         strap_q;
    logic         strap_locked;

    always_comb begin
        strap_state_d = strap_state_q;
        unique case (strap_state_q)
            SP_SAMPLE: strap_state_d = SP_LOCKED;
            SP_LOCKED: strap_state_d = SP_LOCKED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) strap_state_q <= SP_SAMPLE;
        else        strap_state_q <= strap_state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          strap_q <= 1'b0;
        else if (strap_state_q == SP_SAMPLE) strap_q <= mode_strap;
    end

    assign strap_locked = (strap_state_q == SP_LOCKED);

    // stop synchronizers
    logic cpu_halt_s;
    logic pin_s;
    logic pci_halt;

    clkg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_cpu (
        .clk(clk), .rst_n(rst_n), .d(~cpu_stop_n), .q(cpu_halt_s)
    );
    clkg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_pin (
        .clk(clk), .rst_n(rst_n), .d(pcistop_pin), .q(pin_s)
    );

    assign pci_halt = ~strap_q & ~pin_s;

    // test-mode crystal dividers
    logic div2, div4;
    clkg_xdiv u_xdiv (
        .clk(clk), .rst_n(rst_n), .xtal(xtal_src), .div2(div2), .div4(div4)
    );

    logic ref_mux, s48_mux, s24_mux;
    assign ref_mux = test_en ? xtal_src : ref_src;
    assign s48_mux = test_en ? div2     : usb48_src;
    assign s24_mux = test_en ? div4     : usb24_src;

    // per-output gate sources and requests
    logic [NG-1:0] g_src, g_stop, g_out;

    always_comb begin
        g_src[IDX_CPU]   = cpu_src;
        g_stop[IDX_CPU]  = cpu_halt_s | ~en_cpu;
        g_src[IDX_CPUF]  = cpu_src;
        g_stop[IDX_CPUF] = ~en_cpu_free;
        g_src[IDX_PCIF]  = pci_src;
        g_stop[IDX_PCIF] = ~en_pci_free;
        g_src[IDX_REF0]  = ref_mux;
        g_stop[IDX_REF0] = ~strap_q | ~en_ref0;
        g_src[IDX_REF1]  = ref_mux;
        g_stop[IDX_REF1] = ~en_ref1;
        g_src[IDX_APIC]  = ref_mux;
        g_stop[IDX_APIC] = ~en_apic;
        g_src[IDX_U48]   = s48_mux;
        g_stop[IDX_U48]  = ~en_48;
        g_src[IDX_U24]   = s24_mux;
        g_stop[IDX_U24]  = ~en_24;
        for (int i = 0; i < N_PCI; i++) begin
            g_src[IDX_PCI+i]  = pci_src;
            g_stop[IDX_PCI+i] = pci_halt | ~en_pci[i];
        end
        for (int g = 0; g < N_SDG; g++) begin
            g_src[IDX_SDG+g]  = sdram_src;
            g_stop[IDX_SDG+g] = ~en_sdram[g];
        end
    end

    for (genvar gi = 0; gi < NG; gi++) begin : g_gate
        clkg_gate u_gate (
            .clk(clk), .rst_n(rst_n),
            .src(g_src[gi]), .stop(g_stop[gi]), .gout(g_out[gi])
        );
    end

    assign cpu_out        = g_out[IDX_CPU];
    assign cpu_free_out   = g_out[IDX_CPUF];
    assign pci_free_out   = g_out[IDX_PCIF];
    assign ref0_out       = g_out[IDX_REF0];
    assign ref1_out       = g_out[IDX_REF1];
    assign apic_out       = g_out[IDX_APIC];
    assign out48          = g_out[IDX_U48];
    assign out24          = g_out[IDX_U24];
    assign pci_out        = g_out[IDX_PCI +: N_PCI];
    assign sdram_free_out = sdram_src;

    for (genvar sg = 0; sg < N_SDG; sg++) begin : g_sdg
        for (genvar sk = 0; sk < SDR_PER_GRP; sk++) begin : g_bit
            assign sdram_out[sg*SDR_PER_GRP+sk] = g_out[IDX_SDG+sg];
        end
    end

    // operating mode decode
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_drive <= 1'b1;
            spread_on <= 1'b0;
        end else begin
            unique case (op_mode)
                OPM_NORMAL, OPM_RSVD: begin out_drive <= 1'b1; spread_on <= 1'b0; end
                OPM_SPREAD:           begin out_drive <= 1'b1; spread_on <= 1'b1; end
                OPM_HIZ:              begin out_drive <= 1'b0; spread_on <= 1'b0; end
            endcase
        end
    end
endmodule

// File: rtl/clk_gate_ctrl_chk.sv
module clk_gate_ctrl_chk (
    input logic clk,
    input logic rst_n,
    input logic cpu_src,
    input logic cpu_out,
    input logic pci_src,
    input logic pci_out0,
    input logic pci_free_out,
    input logic strap_q,
    input logic strap_locked
);
    assert_cpu_fall_with_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cpu_out) |-> $fell(cpu_src));

    assert_cpu_rise_with_src_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cpu_out) |-> $rose(cpu_src));

    assert_pci_fall_with_src_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pci_out0) |-> $fell(pci_src));

    assert_pci_free_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pci_free_out) |-> $rose(pci_src));

    assert_strap_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (strap_locked && $past(strap_locked)) |-> $stable(strap_q));
endmodule

bind clk_gate_ctrl clk_gate_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_src(cpu_src), .cpu_out(cpu_out),
    .pci_src(pci_src), .pci_out0(pci_out[0]), .pci_free_out(pci_free_out),
    .strap_q(strap_q), .strap_locked(strap_locked)
);

// File: tb/sim_clk_gate_ctrl.sv
module sim_clk_gate_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP  = 5;
    localparam int NSD = 12;

    logic clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    logic rst_n = 1'b0;
    logic cpu_s = 0, pci_s = 0, ref_s = 0, sd_s = 0, u48_s = 0, u24_s = 0, xtal_s = 0;
    logic cpu_stop_n = 1, pin = 1, strap = 0, test_en = 0;
    logic [1:0] op_mode = 2'b00;
    logic en_cpu = 1, en_cpuf = 1, en_pcif = 1, en_r0 = 1, en_r1 = 1, en_ap = 1, en48 = 1, en24 = 1;
    logic [NP-1:0] en_pci = '1;
    logic [2:0] en_sd = '1;

    logic cpu_out, cpu_free_out, pci_free_out, ref0_out, ref1_out, apic_out, out48, out24;
    logic sdram_free_out, out_drive, spread_on;
    logic [NP-1:0] pci_out;
    logic [NSD-1:0] sdram_out;

    clk_gate_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cpu_src(cpu_s), .pci_src(pci_s), .ref_src(ref_s),
        .sdram_src(sd_s), .usb48_src(u48_s), .usb24_src(u24_s), .xtal_src(xtal_s),
        .cpu_stop_n(cpu_stop_n), .pcistop_pin(pin), .mode_strap(strap), .op_mode(op_mode),
        .test_en(test_en), .en_cpu(en_cpu), .en_cpu_free(en_cpuf), .en_pci(en_pci),
        .en_pci_free(en_pcif), .en_ref0(en_r0), .en_ref1(en_r1), .en_apic(en_ap),
        .en_48(en48), .en_24(en24), .en_sdram(en_sd), .cpu_out(cpu_out),
        .cpu_free_out(cpu_free_out), .pci_out(pci_out), .pci_free_out(pci_free_out),
        .ref0_out(ref0_out), .ref1_out(ref1_out), .apic_out(apic_out), .out48(out48),
        .out24(out24), .sdram_out(sdram_out), .sdram_free_out(sdram_free_out),
        .out_drive(out_drive), .spread_on(spread_on)
    );

    // source clocks: cpu/sdram period 4, pci 8, ref/24 12, 48 6, xtal 8
    int ph = 0;
    always @(posedge clk) begin
        #1;
        ph = ph + 1;
        cpu_s  = (ph % 4) < 2;
        sd_s   = (ph % 4) >= 2;
        pci_s  = (ph % 8) < 4;
        ref_s  = (ph % 12) >= 6;
        u24_s  = (ph % 12) < 6;
        u48_s  = (ph % 6) < 3;
        xtal_s = (ph % 8) < 4;
    end

    int total = 0;
    int bad = 0;

    localparam int OB_CPU = 0, OB_CPUF = 1, OB_PCI = 2, OB_PCIF = 3, OB_REF0 = 4,
                   OB_REF1 = 5, OB_APIC = 6, OB_48 = 7, OB_24 = 8, OB_SD = 9,
                   OB_SDF = 10, OB_DRV = 11, OB_SPR = 12;
    localparam int K_LOW = 0, K_FOLLOW = 1, K_HIGH = 2, K_XTAL = 3;

    typedef struct {
        int          id;
        logic [31:0] exp;
        string       req;
    } sb_item_t;
    sb_item_t sbq[$];
    sb_item_t it;

    function automatic logic [31:0] msk(int id);
        if (id == OB_PCI) return 32'h1F;
        if (id == OB_SD)  return 32'hFFF;
        return 32'h1;
    endfunction

    function automatic logic [31:0] obs(int id);
        case (id)
            OB_CPU:  return 32'(cpu_out);
            OB_CPUF: return 32'(cpu_free_out);
            OB_PCI:  return 32'(pci_out);
            OB_PCIF: return 32'(pci_free_out);
            OB_REF0: return 32'(ref0_out);
            OB_REF1: return 32'(ref1_out);
            OB_APIC: return 32'(apic_out);
            OB_48:   return 32'(out48);
            OB_24:   return 32'(out24);
            OB_SD:   return 32'(sdram_out);
            OB_SDF:  return 32'(sdram_free_out);
            OB_DRV:  return 32'(out_drive);
            default: return 32'(spread_on);
        endcase
    endfunction

    function automatic logic [31:0] src_of(int id);
        case (id)
            OB_CPU, OB_CPUF:          return 32'(cpu_s);
            OB_PCI:                   return 32'({NP{pci_s}});
            OB_PCIF:                  return 32'(pci_s);
            OB_REF0, OB_REF1, OB_APIC: return 32'(ref_s);
            OB_48:                    return 32'(u48_s);
            OB_24:                    return 32'(u24_s);
            OB_SD:                    return 32'({NSD{sd_s}});
            default:                  return 32'(sd_s);
        endcase
    endfunction

    // driver: queue one expectation per cycle for n cycles
    task automatic sb_win(int n, int id, int kind, string req);
        for (int i = 0; i < n; i++) begin
            sb_item_t x;
            @(posedge clk);
            #2;
            x.id  = id;
            x.req = req;
            case (kind)
                K_LOW:    x.exp = 32'h0;
                K_FOLLOW: x.exp = src_of(id);
                K_HIGH:   x.exp = msk(id);
                default:  x.exp = 32'(xtal_s);
            endcase
            sbq.push_back(x);
        end
    endtask

    // monitor: compare at the falling clock edge
    always @(negedge clk) begin
        while (sbq.size() > 0) begin
            logic [31:0] act;
            it  = sbq.pop_front();
            act = obs(it.id) & msk(it.id);
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s output=%0d act=%h exp=%h", it.req, it.id, act, it.exp);
            end
        end
    end

    task automatic chk(logic ok, string req, int act, int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // runt monitor on stoppable outputs (R2, R3): every high phase must be full
    int clen = 0, plen = 0, runts = 0;
    logic x_q = 0, o48_q = 0, o24_q = 0;
    int x_r = 0, r48 = 0, r24 = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            clen = 0;
            plen = 0;
        end else begin
            if (cpu_out) clen++;
            else begin
                if (clen != 0 && clen != 2) runts++;
                clen = 0;
            end
            if (pci_out[0]) plen++;
            else begin
                if (plen != 0 && plen != 4) runts++;
                plen = 0;
            end
        end
        if (xtal_s && !x_q) x_r++;
        if (out48 && !o48_q) r48++;
        if (out24 && !o24_q) r24++;
        x_q = xtal_s;
        o48_q = out48;
        o24_q = out24;
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=timeout exp=finish");
        finish_run();
    end

    initial begin
        // R1: outputs low in reset
        fork
            sb_win(4, OB_CPU, K_LOW, "R1 reset");
            sb_win(4, OB_PCI, K_LOW, "R1 reset");
            sb_win(4, OB_48,  K_LOW, "R1 reset");
        join
        rst_n = 1'b1;
        cyc(30);

        // normal running, strap 0 -> ref0 held low (R6), status (R10)
        fork
            sb_win(16, OB_CPU,  K_FOLLOW, "R1 run after reset");
            sb_win(16, OB_PCI,  K_FOLLOW, "R1 pci run");
            sb_win(16, OB_SD,   K_FOLLOW, "R4 sdram run");
            sb_win(16, OB_48,   K_FOLLOW, "R4 48 run");
            sb_win(16, OB_24,   K_FOLLOW, "R4 24 run");
            sb_win(16, OB_REF0, K_LOW,    "R6 ref0 low strap0");
            sb_win(4,  OB_DRV,  K_HIGH,   "R10 mode00 drive");
            sb_win(4,  OB_SPR,  K_LOW,    "R10 mode00 spread");
        join

        // R2/R4/R9: cpu stop
        cpu_stop_n = 1'b0;
        cyc(12);
        fork
            sb_win(16, OB_CPU,  K_LOW,    "R2 cpu stopped");
            sb_win(16, OB_CPUF, K_FOLLOW, "R4 cpu free");
            sb_win(16, OB_REF1, K_FOLLOW, "R4 ref1");
            sb_win(16, OB_APIC, K_FOLLOW, "R4 apic");
            sb_win(16, OB_SD,   K_FOLLOW, "R4 sdram");
            sb_win(16, OB_48,   K_FOLLOW, "R4 48");
            sb_win(16, OB_24,   K_FOLLOW, "R4 24");
            sb_win(16, OB_SDF,  K_FOLLOW, "R9 sdram free");
        join
        cpu_stop_n = 1'b1;
        cyc(12);
        sb_win(16, OB_CPU, K_FOLLOW, "R3 cpu restart");

        // R6: pci stop under strap 0
        pin = 1'b0;
        cyc(13);
        fork
            sb_win(16, OB_PCI,  K_LOW,    "R6 pci stopped");
            sb_win(16, OB_PCIF, K_FOLLOW, "R6 pci free runs");
            sb_win(16, OB_REF0, K_LOW,    "R6 ref0 low");
        join
        pin = 1'b1;
        cyc(15);
        sb_win(16, OB_PCI, K_FOLLOW, "R3 pci restart");

        // R8/R9: enables
        en_cpu = 1'b0;
        en_sd = 3'b000;
        en48 = 1'b0;
        cyc(16);
        fork
            sb_win(16, OB_CPU, K_LOW,    "R8 cpu disabled");
            sb_win(16, OB_SD,  K_LOW,    "R8 sdram disabled");
            sb_win(16, OB_48,  K_LOW,    "R8 48 disabled");
            sb_win(16, OB_DRV, K_HIGH,   "R8 not floated");
            sb_win(16, OB_SDF, K_FOLLOW, "R9 free ignores enable");
        join
        en_cpu = 1'b1;
        en_sd = 3'b111;
        en48 = 1'b1;
        cyc(20);
        sb_win(8, OB_CPU, K_FOLLOW, "R3 cpu re-enabled");

        // R10: operating modes
        op_mode = 2'b10;
        cyc(2);
        fork
            sb_win(4, OB_SPR, K_HIGH,   "R10 spread on");
            sb_win(4, OB_DRV, K_HIGH,   "R10 spread drive");
            sb_win(4, OB_CPU, K_FOLLOW, "R10 spread cpu");
        join
        op_mode = 2'b11;
        cyc(2);
        fork
            sb_win(4, OB_DRV, K_LOW, "R10 hiz drive");
            sb_win(4, OB_SPR, K_LOW, "R10 hiz spread");
        join
        op_mode = 2'b01;
        cyc(2);
        fork
            sb_win(4, OB_DRV, K_HIGH, "R10 mode01 drive");
            sb_win(4, OB_SPR, K_LOW,  "R10 mode01 spread");
        join
        op_mode = 2'b00;

        // R11: test mode
        test_en = 1'b1;
        cyc(20);
        fork
            sb_win(16, OB_REF1, K_XTAL, "R11 ref1 xtal");
            sb_win(16, OB_APIC, K_XTAL, "R11 apic xtal");
        join
        begin
            int x0, a0, b0;
            x0 = x_r; a0 = r48; b0 = r24;
            cyc(64);
            chk((x_r - x0) == 8, "R11 xtal edges", x_r - x0, 8);
            chk((r48 - a0) >= 3 && (r48 - a0) <= 5, "R11 out48 half rate", r48 - a0, 4);
            chk((r24 - b0) >= 1 && (r24 - b0) <= 3, "R11 out24 quarter rate", r24 - b0, 2);
        end
        test_en = 1'b0;
        cyc(20);

        // R5/R7: strap 1, then strap pin changed after capture
        rst_n = 1'b0;
        strap = 1'b1;
        cyc(4);
        rst_n = 1'b1;
        cyc(3);
        strap = 1'b0;
        cyc(30);
        sb_win(16, OB_REF0, K_FOLLOW, "R5 R7 ref0 runs strap1");
        pin = 1'b0;
        cyc(13);
        fork
            sb_win(16, OB_PCI,  K_FOLLOW, "R7 pci ignores pin");
            sb_win(16, OB_REF0, K_FOLLOW, "R5 strap change ignored");
        join
        pin = 1'b1;
        cyc(4);

        chk(runts == 0, "R2 R3 no runt high phase", runts, 0);
        finish_run();
    end
endmodule